// File: doc/BRIEF.md
# Nth-chance clock page-frame victim selector

This block picks a physical page frame to reclaim when memory runs short. Its choice approximates least-recently-used. Each frame carries three pieces of state: a use flag, a dirty flag, and a small count of sweeps that have passed since the frame was last referenced. Load and store traffic reports references on a single-cycle port, and a store also marks the frame dirty.

When a victim is requested, a rotating hand visits one frame per cycle. A frame that was used since the last visit gets its use flag cleared and its sweep count zeroed. An idle frame whose count is still below a runtime threshold has the count raised by one. The first idle frame whose count has reached the threshold is chosen.

A clean choice is returned at once. A dirty choice is first offered on a write-back request, which stays raised until it is acknowledged. Frames that software has pinned are never chosen. If two full sweeps pass without a choice, the request ends with a failure indication.

Top module: `nth_clock_reclaim`

## Requirements
- R1: After reset, no frame is referenced or dirty, every sweep count is zero, the hand points at frame 0, and vic_done and wb_req are low.
- R2: A reference sets the frame's use flag. When the hand visits a frame whose use flag is set, it clears the flag, zeroes the frame's count and moves on without choosing that frame.
- R3: When the hand visits an unpinned, unused frame whose count is below `chances`, it adds one to the count and moves on.
- R4: When the hand visits an unpinned, unused frame whose count is at least `chances`, that frame is chosen. With `chances` = 0, this makes the block choose the first unused frame.
- R5: The hand advances by exactly one frame per cycle and wraps from the last frame to frame 0. Counted from the accepting clock edge, a victim found on the k-th visit raises vic_done k cycles later. After a request completes, the next request starts at the frame after the victim.
- R6: A dirty victim raises wb_req with wb_frame equal to the victim. Both are held unchanged, and vic_done stays low, until wb_ack is sampled high.
- R7: When wb_ack is sampled high, the victim's dirty flag and count are cleared, and in the next cycle vic_done is high with vic_ok = 1 and vic_frame = victim. A clean victim's count is also cleared, and it completes without a write-back.
- R8: A reference to the frame that the hand is visiting in the same cycle treats that frame as used, so it is not chosen in that visit.
- R9: The hand passes over any frame whose pin_mask bit is 1 without changing its state, and never chooses it.
- R10: If 2*FRAMES visits pass without a choice, vic_done rises exactly 2*FRAMES cycles after the accepting edge with vic_ok = 0. The frame state is kept as updated by those visits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A frame was referenced this cycle |
| ref_frame | input | IW | Index of the referenced frame |
| ref_dirty | input | 1 | The reference was a store, so the frame becomes dirty |
| pin_mask | input | FRAMES | 1 = frame is pinned and may never be chosen |
| chances | input | CW | Number of idle sweeps a frame is allowed before it may be chosen |
| vic_req | input | 1 | Request a victim; sampled only while the block is idle |
| vic_done | output | 1 | One-cycle pulse: the request has completed |
| vic_ok | output | 1 | Qualifies vic_done: 1 = a victim was found, 0 = failure |
| vic_frame | output | IW | Index of the chosen frame, valid with vic_done and vic_ok |
| wb_req | output | 1 | The chosen frame is dirty and must be written back |
| wb_frame | output | IW | Frame to write back |
| wb_ack | input | 1 | The write-back has finished |

## Verification
A hand that is stuck or skips frames shows up as a vic_done latency that differs from the number of visits the scenario predicts. It also shows up as the wrong vic_frame on the following request, within a single request. A count that is wrongly stepped or not cleared moves the result of a threshold scenario by whole sweeps, for example 17 cycles instead of 1. A use flag that is lost shows as an early victim, and one that survives a visit shows as a missed victim. A dirty flag that is not cleared shows as a second wb_req on the next request to the same frame. A pinned frame that is chosen, or a failure that arrives early, is visible at vic_done on the request concerned.

// File: rtl/nth_clock_reclaim.sv
module nth_clock_reclaim #(
  parameter int FRAMES = 16,
  parameter int CW     = 3,
  localparam int IW    = $clog2(FRAMES),
  localparam int SW    = $clog2(2 * FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [IW-1:0]     ref_frame,
  input  logic              ref_dirty,
  input  logic [FRAMES-1:0] pin_mask,
  input  logic [CW-1:0]     chances,
  input  logic              vic_req,
  output logic              vic_done,
  output logic              vic_ok,
  output logic [IW-1:0]     vic_frame,
  output logic              wb_req,
  output logic [IW-1:0]     wb_frame,
  input  logic              wb_ack
);
  localparam logic [SW-1:0] LAST = SW'(2 * FRAMES - 1);

  typedef enum logic [1:0] {IDLE, SCAN, WBACK} st_t;
  st_t st;

  logic [FRAMES-1:0] use_q, dirty_q;
  logic [CW-1:0]     cnt_q [FRAMES];
  logic [IW-1:0]     hand;
  logic [SW-1:0]     steps;

  wire visit = (st == SCAN) && !pin_mask[hand];
  wire hit   = ref_valid && (ref_frame == hand);
  wire used  = use_q[hand] | hit;
  wire pick  = visit && !used && (cnt_q[hand] >= chances);
  wire ack   = (st == WBACK) && wb_ack;

  assign wb_req   = (st == WBACK);
  assign wb_frame = hand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q   <= '0;
      dirty_q <= '0;
    end else begin
      for (int f = 0; f < FRAMES; f++) begin
        if (visit && used && hand == IW'(f))
          use_q[f] <= 1'b0;
        else if (ref_valid && ref_frame == IW'(f))
          use_q[f] <= 1'b1;
        if (ref_valid && ref_dirty && ref_frame == IW'(f))
          dirty_q[f] <= 1'b1;
        else if (ack && hand == IW'(f))
          dirty_q[f] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      hand      <= '0;
      steps     <= '0;
      vic_done  <= 1'b0;
      vic_ok    <= 1'b0;
      vic_frame <= '0;
      for (int f = 0; f < FRAMES; f++) cnt_q[f] <= '0;
    end else begin
      vic_done <= 1'b0;
      case (st)
        IDLE: if (vic_req) begin
          st    <= SCAN;
          steps <= '0;
        end
        SCAN: begin
          steps <= steps + 1'b1;
          hand  <= hand + 1'b1;
          if (visit) begin
            if (used)
              cnt_q[hand] <= '0;
            else if (!pick)
              cnt_q[hand] <= cnt_q[hand] + 1'b1;
          end
          if (pick && dirty_q[hand]) begin
            st   <= WBACK;
            hand <= hand;
          end else if (pick) begin
            cnt_q[hand] <= '0;
            st        <= IDLE;
            vic_done  <= 1'b1;
            vic_ok    <= 1'b1;
            vic_frame <= hand;
          end else if (steps == LAST) begin
            st       <= IDLE;
            vic_done <= 1'b1;
            vic_ok   <= 1'b0;
          end
        end
        WBACK: if (wb_ack) begin
          cnt_q[hand] <= '0;
          hand      <= hand + 1'b1;
          st        <= IDLE;
          vic_done  <= 1'b1;
          vic_ok    <= 1'b1;
          vic_frame <= hand;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_frame));
  a_r6_no_done_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !vic_done);
  a_r7_ack_returns: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> vic_done && vic_ok && vic_frame == $past(wb_frame));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vic_done |=> !vic_done);
  a_r9_not_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> !pin_mask[wb_frame]);
endmodule

// File: tb/test_nth_clock_reclaim.sv
`timescale 1ns/1ps
module test_nth_clock_reclaim;
  localparam int FRAMES = 16;
  localparam int CW = 3;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic ref_valid = 0, ref_dirty = 0, vic_req = 0, wb_ack = 0;
  logic [IW-1:0] ref_frame = '0;
  logic [FRAMES-1:0] pin_mask = '0;
  logic [CW-1:0] chances = '0;
  logic vic_done, vic_ok, wb_req;
  logic [IW-1:0] vic_frame, wb_frame;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  nth_clock_reclaim #(.FRAMES(FRAMES), .CW(CW)) i_nth_clock_reclaim (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .ref_dirty(ref_dirty), .pin_mask(pin_mask), .chances(chances),
    .vic_req(vic_req), .vic_done(vic_done), .vic_ok(vic_ok),
    .vic_frame(vic_frame), .wb_req(wb_req), .wb_frame(wb_frame), .wb_ack(wb_ack));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ref_valid = 0; vic_req = 0; wb_ack = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic touch(input int f, input bit dirty);
    @(negedge clk); ref_valid = 1; ref_frame = IW'(f); ref_dirty = dirty;
    @(negedge clk); ref_valid = 0; ref_dirty = 0;
  endtask

  task automatic request(input bit hit_first, input int hit_frame, input int ack_delay,
                         output int frame, output int ok, output int cycles,
                         output int wb_seen, output int wb_at);
    int wbc;
    wbc = 0; wb_seen = 0; wb_at = -1; cycles = 0;
    @(negedge clk); vic_req = 1;
    @(posedge clk);
    @(negedge clk); vic_req = 0;
    if (hit_first) begin ref_valid = 1; ref_frame = IW'(hit_frame); end
    while (cycles < 200) begin
      @(posedge clk); cycles++;
      @(negedge clk);
      ref_valid = 0;
      if (vic_done) break;
      if (wb_req) begin
        wb_seen = 1; wb_at = int'(wb_frame); wbc++;
        if (wbc > ack_delay) wb_ack = 1;
      end
    end
    wb_ack = 0;
    frame = int'(vic_frame); ok = int'(vic_ok);
  endtask

  int fr, ok, cy, ws, wa;

  task automatic t_reset();
    do_reset();
    check("R1 vic_done after reset", int'(vic_done), 0);
    check("R1 wb_req after reset", int'(wb_req), 0);
  endtask

  task automatic t_plain();
    do_reset(); chances = 0; pin_mask = '0;
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R1/R4 first victim frame", fr, 0);
    check("R4 first victim ok", ok, 1);
    check("R5 one visit latency", cy, 1);
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R5 hand resumes at next frame", fr, 1);
  endtask

  task automatic t_used();
    do_reset(); chances = 0; pin_mask = '0;
    touch(0, 0); touch(1, 0); touch(2, 0);
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R2 used frames skipped", fr, 3);
    check("R5 one frame per cycle", cy, 4);
    check("R7 clean victim no writeback", ws, 0);
  endtask

  task automatic t_nth();
    do_reset(); chances = 1; pin_mask = '0;
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R3 count climbs over one sweep", cy, 17);
    check("R3 victim frame after wrap", fr, 0);
  endtask

  task automatic t_fail();
    do_reset(); chances = 2; pin_mask = '0;
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R10 failure reported", ok, 0);
    check("R10 failure after two sweeps", cy, 2 * FRAMES);
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R4 count at threshold chosen", fr, 0);
    check("R4 chosen on first visit", cy, 1);
  endtask

  task automatic t_pinned();
    do_reset(); chances = 0; pin_mask = 16'h001F;
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R9 pinned frames skipped", fr, 5);
    check("R9 skip latency", cy, 6);
    do_reset(); pin_mask = '1;
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R9 all pinned gives failure", ok, 0);
    pin_mask = '0;
  endtask

  task automatic t_dirty();
    do_reset(); chances = 0; pin_mask = 16'hFFFE;
    touch(0, 1);
    request(0, 0, 3, fr, ok, cy, ws, wa);
    check("R6 writeback raised", ws, 1);
    check("R6 writeback frame", wa, 0);
    check("R6 done waits for ack", cy, 21);
    check("R7 victim returned", fr, 0);
    check("R7 victim ok", ok, 1);
    request(0, 0, 0, fr, ok, cy, ws, wa);
    check("R7 dirty flag cleared", ws, 0);
    check("R7 counter cleared, reclaimed again", cy, 16);
    pin_mask = '0;
  endtask

  task automatic t_prio();
    do_reset(); chances = 0; pin_mask = 16'hFFFC;
    request(1, 0, 0, fr, ok, cy, ws, wa);
    check("R8 same-cycle reference wins", fr, 1);
    check("R8 latency", cy, 2);
    pin_mask = '0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_used();
    t_nth();
    t_fail();
    t_pinned();
    t_dirty();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule